// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block holds two one-word bypass registers that let two ports, each running on its own clock, hand single words to each other outside the data FIFOs. Mailbox 1 is loaded from port A and read from port B. Mailbox 2 is loaded from port B and read from port A. Each mailbox has an active-low full flag in the reader's clock domain. The flag drops a few reader clocks after a load and rises on the reader clock edge that takes the word. While a word is still outstanding, the writer's port refuses further loads of that mailbox.

Each port has a chip select, a direction bit, an access enable and a mailbox select. When a port is set up for reading, its output bus carries one of two sources. With the mailbox select high it carries the opposite mailbox. With the select low it carries the FIFO output word, which arrives on that port's FIFO data input. Load and release events cross between the two clocks as toggle bits, each passed through a short synchronizer chain. The stored word does not change between a load and its release, so the reader may take it straight from the bus once the flag is low. Each mailbox has its own reset, meant to be driven by the reset of the FIFO that travels in the same direction.

Top module: `xdom_mailbox`

## Requirements
- R1: A port-A cycle with a_cs_n=0, a_en=1, a_wr=1 and a_mbx=1, taken while mailbox 1 is free, stores a_din. mail1_full_n then goes to 0 within SYNC_STAGES+1 rising edges of clk_b.
- R2: A mailbox-1 load attempt made while mailbox 1 is still occupied leaves the stored word unchanged. The mailbox counts as occupied from its last accepted load until its release has reached port A.
- R3: A port-B cycle with b_cs_n=0, b_en=1, b_wr=0 and b_mbx=1 sets mail1_full_n to 1 at that clk_b edge. A new mailbox-1 load is accepted once SYNC_STAGES+1 clk_a edges have passed since that read.
- R4: Mailbox 2 behaves the same way with the roles of the ports swapped. It is loaded by a port-B cycle with b_wr=1 and b_mbx=1, which drives mail2_full_n to 0 in the clk_a domain. It is released by a port-A cycle with a_wr=0 and a_mbx=1.
- R5: While rst_m1_n is low, mail1_full_n is 1, mailbox 1 holds zero and nothing is outstanding for it. rst_m2_n does the same for mailbox 2, and each reset leaves the other mailbox untouched.
- R6: a_dout_oe is 1 exactly when a_cs_n=0 and a_wr=0. When it is 1, a_dout equals mailbox 2 if a_mbx=1, or a_fifo_q if a_mbx=0; when it is 0, a_dout is zero. Port B follows the same rule with mailbox 1 and b_fifo_q.
- R7: A mailbox read while the flag is high (empty) changes nothing: the flag stays high and the next load completes normally.
- R8: A cycle with chip select high, enable low or mailbox select low neither loads nor releases a mailbox.
- R9: While a mailbox flag is low, the reader's bus with mailbox select high shows the word that was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_m1_n | input | 1 | Active-low reset of mailbox 1, asynchronous |
| rst_m2_n | input | 1 | Active-low reset of mailbox 2, asynchronous |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction, 1 write, 0 read |
| a_en | input | 1 | Port A access enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | WIDTH | Port A write data |
| a_fifo_q | input | WIDTH | FIFO output word shown on port A |
| a_dout | output | WIDTH | Port A read bus |
| a_dout_oe | output | 1 | Port A bus drive enable |
| mail2_full_n | output | 1 | Mailbox 2 full flag, active low, clk_a domain |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B direction, 1 write, 0 read |
| b_en | input | 1 | Port B access enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | WIDTH | Port B write data |
| b_fifo_q | input | WIDTH | FIFO output word shown on port B |
| b_dout | output | WIDTH | Port B read bus |
| b_dout_oe | output | 1 | Port B bus drive enable |
| mail1_full_n | output | 1 | Mailbox 1 full flag, active low, clk_b domain |

## Verification
The bench builds the block with its defaults, WIDTH=36 and SYNC_STAGES=2, and runs the two clocks at unrelated periods, so their edges slide past each other and now and then coincide. This makes both the short and the long synchronizer latency occur, and the flag window in R1 is checked against its bound and not against one exact cycle. The full 36-bit width lets patterns in the upper bits show whether a blocked load corrupted the held word.

// File: rtl/xdom_mailbox.sv
`timescale 1ns/100ps
module xdom_mailbox #(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst_m1_n,
  input  logic             rst_m2_n,
  input  logic             a_cs_n,
  input  logic             a_wr,
  input  logic             a_en,
  input  logic             a_mbx,
  input  logic [WIDTH-1:0] a_din,
  input  logic [WIDTH-1:0] a_fifo_q,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_dout_oe,
  output logic             mail2_full_n,
  input  logic             b_cs_n,
  input  logic             b_wr,
  input  logic             b_en,
  input  logic             b_mbx,
  input  logic [WIDTH-1:0] b_din,
  input  logic [WIDTH-1:0] b_fifo_q,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_dout_oe,
  output logic             mail1_full_n
);

  localparam int TOP = SYNC_STAGES - 1;

  logic a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd;
  assign a_mb_wr = !a_cs_n && a_en && a_wr && a_mbx;
  assign a_mb_rd = !a_cs_n && a_en && !a_wr && a_mbx;
  assign b_mb_wr = !b_cs_n && b_en && b_wr && b_mbx;
  assign b_mb_rd = !b_cs_n && b_en && !b_wr && b_mbx;

  // mailbox 1: port A loads, port B takes
  logic [WIDTH-1:0] mail1_q;
  logic             m1_ld_tog, m1_ack_tog;
  logic [TOP:0]     m1_ld_sync, m1_ack_sync;
  logic             m1_busy, m1_pend;

  assign m1_busy = m1_ld_tog != m1_ack_sync[TOP];
  assign m1_pend = m1_ld_sync[TOP] != m1_ack_tog;

  always_ff @(posedge clk_a or negedge rst_m1_n) begin
    if (!rst_m1_n) begin
      mail1_q     <= '0;
      m1_ld_tog   <= 1'b0;
      m1_ack_sync <= '0;
    end else begin
      m1_ack_sync <= {m1_ack_sync[TOP-1:0], m1_ack_tog};
      if (a_mb_wr && !m1_busy) begin
        mail1_q   <= a_din;
        m1_ld_tog <= ~m1_ld_tog;
      end
    end
  end

  always_ff @(posedge clk_b or negedge rst_m1_n) begin
    if (!rst_m1_n) begin
      m1_ld_sync <= '0;
      m1_ack_tog <= 1'b0;
    end else begin
      m1_ld_sync <= {m1_ld_sync[TOP-1:0], m1_ld_tog};
      if (b_mb_rd) m1_ack_tog <= m1_ld_sync[TOP];
    end
  end

  assign mail1_full_n = !m1_pend;

  // mailbox 2: port B loads, port A takes
  logic [WIDTH-1:0] mail2_q;
  logic             m2_ld_tog, m2_ack_tog;
  logic [TOP:0]     m2_ld_sync, m2_ack_sync;
  logic             m2_busy, m2_pend;

  assign m2_busy = m2_ld_tog != m2_ack_sync[TOP];
  assign m2_pend = m2_ld_sync[TOP] != m2_ack_tog;

  always_ff @(posedge clk_b or negedge rst_m2_n) begin
    if (!rst_m2_n) begin
      mail2_q     <= '0;
      m2_ld_tog   <= 1'b0;
      m2_ack_sync <= '0;
    end else begin
      m2_ack_sync <= {m2_ack_sync[TOP-1:0], m2_ack_tog};
      if (b_mb_wr && !m2_busy) begin
        mail2_q   <= b_din;
        m2_ld_tog <= ~m2_ld_tog;
      end
    end
  end

  always_ff @(posedge clk_a or negedge rst_m2_n) begin
    if (!rst_m2_n) begin
      m2_ld_sync <= '0;
      m2_ack_tog <= 1'b0;
    end else begin
      m2_ld_sync <= {m2_ld_sync[TOP-1:0], m2_ld_tog};
      if (a_mb_rd) m2_ack_tog <= m2_ld_sync[TOP];
    end
  end

  assign mail2_full_n = !m2_pend;

  // read buses
  assign a_dout_oe = !a_cs_n && !a_wr;
  assign b_dout_oe = !b_cs_n && !b_wr;
  assign a_dout = a_dout_oe ? (a_mbx ? mail2_q : a_fifo_q) : '0;
  assign b_dout = b_dout_oe ? (b_mbx ? mail1_q : b_fifo_q) : '0;

  // R2: held word does not move while mailbox 1 is outstanding
  p_hold_busy_r2: assert property (@(posedge clk_a) disable iff (!rst_m1_n)
    m1_busy |=> $stable(mail1_q));

  // R3: a mailbox read on port B frees the flag at that edge
  p_release_r3: assert property (@(posedge clk_b) disable iff (!rst_m1_n)
    b_mb_rd |=> mail1_full_n);

  // R8: flag stays low until a mailbox read arrives
  p_flag_hold_r8: assert property (@(posedge clk_b) disable iff (!rst_m1_n)
    (!mail1_full_n && !b_mb_rd) |=> !mail1_full_n);

  // R4: mirror properties for mailbox 2
  p_hold_busy_r4: assert property (@(posedge clk_b) disable iff (!rst_m2_n)
    m2_busy |=> $stable(mail2_q));

  p_release_r4: assert property (@(posedge clk_a) disable iff (!rst_m2_n)
    a_mb_rd |=> mail2_full_n);

  p_flag_hold2_r8: assert property (@(posedge clk_a) disable iff (!rst_m2_n)
    (!mail2_full_n && !a_mb_rd) |=> !mail2_full_n);

endmodule

// File: tb/xdom_mailbox_tb.sv
`timescale 1ns/100ps
module xdom_mailbox_tb;

  logic clk_a = 1'b0, clk_b = 1'b0;
  always #2.5 clk_a = ~clk_a;
  always #3.7 clk_b = ~clk_b;

  logic rst_m1_n = 1'b0, rst_m2_n = 1'b0;
  logic a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0, a_mbx = 1'b0;
  logic b_cs_n = 1'b1, b_wr = 1'b0, b_en = 1'b0, b_mbx = 1'b0;
  logic [35:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
  logic [35:0] a_dout, b_dout;
  logic a_dout_oe, b_dout_oe, mail1_full_n, mail2_full_n;

  xdom_mailbox u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit mon_on = 0, done = 0;

  // behavioural model: rs 0 empty, 1 settling, 2 full
  logic [35:0] m1_val = '0, m2_val = '0;
  int m1_rs = 0, m2_rs = 0, m1_cnt = 0, m2_cnt = 0;
  int m1_rel = -1, m2_rel = -1;
  bit m1_busy = 0, m2_busy = 0;

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_b) begin
    if (m1_rs == 1) begin m1_cnt++; if (m1_cnt >= 3) m1_rs = 2; end
    if (m2_rel >= 0) begin m2_rel++; if (m2_rel >= 3) begin m2_busy = 0; m2_rel = -1; end end
  end

  always @(posedge clk_a) begin
    if (m2_rs == 1) begin m2_cnt++; if (m2_cnt >= 3) m2_rs = 2; end
    if (m1_rel >= 0) begin m1_rel++; if (m1_rel >= 3) begin m1_busy = 0; m1_rel = -1; end end
  end

  always @(negedge clk_b) begin
    #1;
    if (mon_on) begin
      logic [35:0] e;
      if (m1_rs != 1) chk(mail1_full_n === (m1_rs != 2), "R1 R3 mail1_full_n", {35'b0, mail1_full_n}, {35'b0, m1_rs != 2});
      e = (!b_cs_n && !b_wr) ? (b_mbx ? m1_val : b_fifo_q) : '0;
      chk(b_dout === e, "R6 b_dout", b_dout, e);
      chk(b_dout_oe === (!b_cs_n && !b_wr), "R6 b_dout_oe", {35'b0, b_dout_oe}, {35'b0, !b_cs_n && !b_wr});
    end
  end

  always @(negedge clk_a) begin
    #1;
    if (mon_on) begin
      logic [35:0] e;
      if (m2_rs != 1) chk(mail2_full_n === (m2_rs != 2), "R4 mail2_full_n", {35'b0, mail2_full_n}, {35'b0, m2_rs != 2});
      e = (!a_cs_n && !a_wr) ? (a_mbx ? m2_val : a_fifo_q) : '0;
      chk(a_dout === e, "R6 a_dout", a_dout, e);
      chk(a_dout_oe === (!a_cs_n && !a_wr), "R6 a_dout_oe", {35'b0, a_dout_oe}, {35'b0, !a_cs_n && !a_wr});
    end
  end

  task automatic a_op(input logic csn, input logic w, input logic e, input logic m, input logic [35:0] d);
    @(negedge clk_a);
    a_cs_n = csn; a_wr = w; a_en = e; a_mbx = m; a_din = d;
    @(posedge clk_a);
    if (!csn && e && m) begin
      if (w) begin
        if (!m1_busy) begin m1_val = d; m1_busy = 1; m1_rs = 1; m1_cnt = 0; end
      end else if (m2_rs == 2) begin
        m2_rs = 0; m2_rel = 0;
      end
    end
  endtask

  task automatic b_op(input logic csn, input logic w, input logic e, input logic m, input logic [35:0] d);
    @(negedge clk_b);
    b_cs_n = csn; b_wr = w; b_en = e; b_mbx = m; b_din = d;
    @(posedge clk_b);
    if (!csn && e && m) begin
      if (w) begin
        if (!m2_busy) begin m2_val = d; m2_busy = 1; m2_rs = 1; m2_cnt = 0; end
      end else if (m1_rs == 2) begin
        m1_rs = 0; m1_rel = 0;
      end
    end
  endtask

  task automatic a_idle(); @(negedge clk_a); a_cs_n = 1; a_en = 0; a_wr = 0; a_mbx = 0; endtask
  task automatic b_idle(); @(negedge clk_b); b_cs_n = 1; b_en = 0; b_wr = 0; b_mbx = 0; endtask
  task automatic wait_a(input int n); repeat (n) @(posedge clk_a); endtask
  task automatic wait_b(input int n); repeat (n) @(posedge clk_b); endtask
  task automatic smp_a(); @(negedge clk_a); #1; endtask
  task automatic smp_b(); @(negedge clk_b); #1; endtask

  task automatic reset_mb(input bit one, input bit two);
    @(negedge clk_a);
    if (one) begin rst_m1_n = 0; m1_val = '0; m1_rs = 0; m1_busy = 0; m1_rel = -1; end
    if (two) begin rst_m2_n = 0; m2_val = '0; m2_rs = 0; m2_busy = 0; m2_rel = -1; end
    wait_b(4);
    @(negedge clk_a);
    rst_m1_n = 1; rst_m2_n = 1;
  endtask

  initial begin
    wait_b(4);
    @(negedge clk_a); rst_m1_n = 1; rst_m2_n = 1;
    mon_on = 1;

    // R5 reset state
    b_op(0, 0, 0, 1, '0); smp_b();
    chk(mail1_full_n === 1, "R5 mail1_full_n after reset", {35'b0, mail1_full_n}, 36'd1);
    chk(b_dout === '0, "R5 mailbox 1 cleared", b_dout, '0);
    a_op(0, 0, 0, 1, '0); smp_a();
    chk(mail2_full_n === 1, "R5 mail2_full_n after reset", {35'b0, mail2_full_n}, 36'd1);
    chk(a_dout === '0, "R5 mailbox 2 cleared", a_dout, '0);
    a_idle(); b_idle();

    // R1 load mailbox 1
    a_op(0, 1, 1, 1, 36'h9_1234_5678); a_idle();
    wait_b(4); smp_b();
    chk(mail1_full_n === 0, "R1 flag low after load", {35'b0, mail1_full_n}, '0);

    // R9 word visible, R8 output-only cycle keeps flag
    b_op(0, 0, 0, 1, '0); smp_b();
    chk(b_dout === 36'h9_1234_5678, "R9 mailbox 1 word", b_dout, 36'h9_1234_5678);
    chk(mail1_full_n === 0, "R8 enable low keeps flag", {35'b0, mail1_full_n}, '0);
    b_op(0, 0, 1, 0, '0); smp_b();
    chk(mail1_full_n === 0, "R8 FIFO read keeps flag", {35'b0, mail1_full_n}, '0);
    b_op(1, 0, 1, 1, '0); smp_b();
    chk(mail1_full_n === 0, "R8 deselected read keeps flag", {35'b0, mail1_full_n}, '0);
    b_idle();

    // R2 blocked load
    a_op(0, 1, 1, 1, 36'hF_FFFF_0000); a_idle();
    wait_b(4);
    b_op(0, 0, 0, 1, '0); smp_b();
    chk(b_dout === 36'h9_1234_5678, "R2 blocked load keeps word", b_dout, 36'h9_1234_5678);

    // R3 release and reload
    b_op(0, 0, 1, 1, '0); smp_b();
    chk(mail1_full_n === 1, "R3 read releases flag", {35'b0, mail1_full_n}, 36'd1);
    b_idle(); wait_a(4);
    a_op(0, 1, 1, 1, 36'h0_A5A5_C3C3); a_idle();
    wait_b(4);
    b_op(0, 0, 0, 1, '0); smp_b();
    chk(b_dout === 36'h0_A5A5_C3C3, "R3 reload accepted", b_dout, 36'h0_A5A5_C3C3);
    chk(mail1_full_n === 0, "R3 reload sets flag", {35'b0, mail1_full_n}, '0);
    b_op(0, 0, 1, 1, '0); b_idle(); wait_a(4);

    // R4 mailbox 2 mirror
    b_op(0, 1, 1, 1, 36'h5_0F0F_1234); b_idle();
    wait_a(4);
    a_op(0, 0, 0, 1, '0); smp_a();
    chk(mail2_full_n === 0, "R4 flag low after load", {35'b0, mail2_full_n}, '0);
    chk(a_dout === 36'h5_0F0F_1234, "R4 mailbox 2 word", a_dout, 36'h5_0F0F_1234);
    a_idle();
    b_op(0, 1, 1, 1, 36'hE_EEEE_EEEE); b_idle();
    wait_a(4);
    a_op(0, 0, 0, 1, '0); smp_a();
    chk(a_dout === 36'h5_0F0F_1234, "R4 blocked load keeps word", a_dout, 36'h5_0F0F_1234);
    a_op(0, 0, 1, 1, '0); smp_a();
    chk(mail2_full_n === 1, "R4 read releases flag", {35'b0, mail2_full_n}, 36'd1);
    a_idle(); wait_b(4);
    b_op(0, 1, 1, 1, 36'h3_3333_0001); b_idle();
    wait_a(4);
    a_op(0, 0, 0, 1, '0); smp_a();
    chk(a_dout === 36'h3_3333_0001, "R4 reload accepted", a_dout, 36'h3_3333_0001);
    a_op(0, 0, 1, 1, '0); a_idle(); wait_b(4);

    // R7 read of empty mailbox
    a_op(0, 0, 1, 1, '0); a_idle(); wait_a(3); smp_a();
    chk(mail2_full_n === 1, "R7 empty read keeps flag high", {35'b0, mail2_full_n}, 36'd1);
    b_op(0, 1, 1, 1, 36'h7_7777_7777); b_idle(); wait_a(4); smp_a();
    chk(mail2_full_n === 0, "R7 next load completes", {35'b0, mail2_full_n}, '0);

    // R6 bus selection patterns
    for (int i = 0; i < 4; i++) begin
      logic [35:0] p;
      p = 36'h1_0000_0001 << i | 36'h8_0000_0000 >> i;
      @(negedge clk_a); a_fifo_q = p;
      a_op(0, 0, 0, 0, '0); smp_a();
      chk(a_dout === p, "R6 port A FIFO word", a_dout, p);
      a_op(0, 1, 0, 0, '0); smp_a();
      chk(a_dout === '0, "R6 port A write direction idles bus", a_dout, '0);
      @(negedge clk_b); b_fifo_q = ~p;
      b_op(0, 0, 0, 0, '0); smp_b();
      chk(b_dout === ~p, "R6 port B FIFO word", b_dout, ~p);
      b_op(1, 0, 0, 1, '0); smp_b();
      chk(b_dout === '0, "R6 port B deselected idles bus", b_dout, '0);
    end
    a_idle(); b_idle();

    // R5 independent resets
    a_op(0, 1, 1, 1, 36'h2_2222_2222); a_idle(); wait_b(4);
    reset_mb(1, 0); smp_b();
    chk(mail1_full_n === 1, "R5 mailbox 1 reset frees flag", {35'b0, mail1_full_n}, 36'd1);
    smp_a();
    chk(mail2_full_n === 0, "R5 mailbox 2 untouched", {35'b0, mail2_full_n}, '0);
    reset_mb(0, 1); smp_a();
    chk(mail2_full_n === 1, "R5 mailbox 2 reset frees flag", {35'b0, mail2_full_n}, 36'd1);

    // R8 non-mailbox and disabled cycles do not load
    a_op(0, 1, 0, 1, 36'h6_6666_6666);
    a_op(1, 1, 1, 1, 36'h6_6666_6667);
    a_op(0, 1, 1, 0, 36'h6_6666_6668); a_idle();
    wait_b(4);
    b_op(0, 0, 0, 1, '0); smp_b();
    chk(mail1_full_n === 1, "R8 no load from gated cycles", {35'b0, mail1_full_n}, 36'd1);
    chk(b_dout === '0, "R8 word unchanged", b_dout, '0);
    b_idle(); wait_b(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule